// File: doc/BRIEF.md
# Dual-Channel Disk Interface Interrupt and Register Decoder

This block is the card-side register logic of a two-channel disk expansion interface. A byte-wide host bus reaches a 16 KB card window. The block decodes that window into several targets: one mask location and one status location per channel, a shared control byte, a four-word identity readout, and the eight taskfile registers plus the alternate status/control register of each attached drive. The taskfile registers are spaced 64 bytes apart.

Each channel's raw drive interrupt passes through a two-flop synchroniser before it reaches that channel's status bit. A channel's interrupt is switched on by any write to its mask location and switched off by any read of that same location. The card raises its host interrupt when at least one channel has both status and enable set. It also gives an ungated pending flag. The control byte has two jobs: it steers the single DMA request/acknowledge pair to one channel, and it opens the alternate window through which taskfile accesses are passed to the drives. Writing zero to the control byte, as a host does at shutdown, closes that window and steers DMA back to channel 0.

Host accesses are single-cycle strobes with no wait states, so the bus needs no back-pressure. Read data is combinational from the address. Side effects take place on the clock edge that ends the access. If `bus_rd` and `bus_wr` are both high in the same cycle, the access is treated as a write.

Top module: `dual_ide_irq_ctrl`

## Requirements
- R1: After reset, both interrupt enables are 0, the control byte reads 0x00, and `host_irq`, `irq_pending`, `drv_dmack`, `tf_cs` and `tf_alt_cs` are all 0.
- R2: A write to offset 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's enable from the next cycle onward, whatever the data. A read of the same offset returns 0xFF and clears the enable from the next cycle onward.
- R3: Status at offset 0x2290 (channel 0) or 0x3290 (channel 1) reads as {7'b0, s}. Here s is the channel's `drv_irq` bit delayed by two clock edges.
- R4: `irq_pending` is the OR of both channels' synchronised status bits and does not depend on the enables.
- R5: `host_irq` is 1 exactly when, for at least one channel, the synchronised status bit and the enable are both 1.
- R6: Identity offsets 0x2280, 0x2284, 0x2288 and 0x228C read {7'b0, CARD_ID[k]} for k = 0..3, in that order. The default CARD_ID is 3.
- R7: The control byte at offset 0x0000 is readable and writable. Its bit 0 selects the DMA channel: `host_dreq` = `drv_dmarq[sel]`, and `host_dack` is forwarded only to `drv_dmack[sel]`, with the other bit held at 0.
- R8: While control bit 5 is 1, an access to base + (n << 6) asserts `tf_cs` one-hot for that channel with `tf_reg` = n, where n is 0..7 and the base is 0x2000 for channel 0 or 0x3000 for channel 1. An access to 0x2380 or 0x3380 asserts `tf_alt_cs` for that channel. `tf_rd` and `tf_wr` follow the access type, and reads return `tf_rdata`. While bit 5 is 0, these offsets behave as unmapped.
- R9: Reads of unmapped offsets return 0xFF. Writes to unmapped offsets and reads of unmapped offsets change no enable and no control bit.
- R10: Writing 0x00 to the control byte closes taskfile access and routes DMA to channel 0 from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Byte offset within the card window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| drv_irq | input | 2 | Raw drive interrupt per channel (asynchronous) |
| host_irq | output | 1 | Enabled interrupt to the host |
| irq_pending | output | 1 | OR of the synchronised status bits |
| drv_dmarq | input | 2 | DMA request from each drive |
| host_dreq | output | 1 | DMA request of the selected channel |
| host_dack | input | 1 | DMA acknowledge from the host |
| drv_dmack | output | 2 | DMA acknowledge to each drive |
| tf_cs | output | 2 | Taskfile select per channel |
| tf_alt_cs | output | 2 | Alternate status/control select per channel |
| tf_reg | output | 3 | Taskfile register index |
| tf_rd | output | 1 | Taskfile read strobe |
| tf_wr | output | 1 | Taskfile write strobe |
| tf_rdata | input | 8 | Read data from the drives |

## Verification
The enable write and the synchroniser output can change in the same clock edge. This case is provoked by raising channel 1's drive interrupt and then issuing the write to 0x3200 one cycle later, so that the second synchroniser stage and the enable flop both load on the same edge. The bench checks that `host_irq` is low just before that edge and high just after it. The reverse case is also checked: a mask read while the status is high must bring `host_irq` down on the next edge, even though `irq_pending` stays high.

// File: rtl/icdc_pkg.sv
package icdc_pkg;
  localparam int ADDR_W   = 14;
  localparam int NCH      = 2;
  localparam int DATA_W   = 8;
  localparam int REG_SHIFT = 6;
  localparam int SEL_W    = $clog2(NCH);

  localparam logic [1:0]  PAGE_CH0  = 2'b10;
  localparam logic [11:0] OFF_MASK  = 12'h200;
  localparam logic [11:0] OFF_STAT  = 12'h290;
  localparam logic [11:0] OFF_IDENT = 12'h280;
  localparam logic [11:0] OFF_ALT   = 12'h380;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  localparam int CTRL_DMA_BIT = 0;
  localparam int CTRL_WIN_BIT = 5;

  typedef struct packed {
    logic            ctrl;
    logic [NCH-1:0]  mask;
    logic [NCH-1:0]  stat;
    logic [NCH-1:0]  tf;
    logic [NCH-1:0]  alt;
    logic            id;
    logic [1:0]      id_idx;
    logic [2:0]      tf_reg;
  } dec_t;
endpackage

// File: rtl/icdc_sync.sv
module icdc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= '0;
        else if (s == 0) st[s] <= d;
        else st[s] <= st[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/icdc_decode.sv
module icdc_decode
  import icdc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_en,
  output dec_t              dec
);
  logic [1:0]  page;
  logic [11:0] off;

  assign page = addr[ADDR_W-1:ADDR_W-2];
  assign off  = addr[11:0];

  always_comb begin
    dec        = '0;
    dec.ctrl   = (addr == CTRL_ADDR);
    dec.tf_reg = off[REG_SHIFT+2:REG_SHIFT];
    for (int c = 0; c < NCH; c++) begin
      if (page == 2'(int'(PAGE_CH0) + c)) begin
        dec.mask[c] = (off == OFF_MASK);
        dec.stat[c] = (off == OFF_STAT);
        dec.alt[c]  = win_en && (off == OFF_ALT);
        dec.tf[c]   = win_en && (off[11:REG_SHIFT+3] == '0) &&
                      (off[REG_SHIFT-1:0] == '0);
        if (c == 0 && off[11:4] == OFF_IDENT[11:4] && off[1:0] == 2'b00) begin
          dec.id     = 1'b1;
          dec.id_idx = off[3:2];
        end
      end
    end
  end
endmodule

// File: rtl/icdc_chan.sv
module icdc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_wr,
  input  logic mask_rd,
  input  logic stat,
  output logic en_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (mask_wr) en_q <= 1'b1;
    else if (mask_rd) en_q <= 1'b0;
  end

  assign irq = stat & en_q;

  assert_mask_write_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> en_q);
  assert_mask_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr) |=> !en_q);
  assert_enable_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(mask_wr));
endmodule

// File: rtl/dual_ide_irq_ctrl.sv
module dual_ide_irq_ctrl
  import icdc_pkg::*;
#(
  parameter logic [3:0] CARD_ID = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    drv_irq,
  output logic              host_irq,
  output logic              irq_pending,
  input  logic [NCH-1:0]    drv_dmarq,
  output logic              host_dreq,
  input  logic              host_dack,
  output logic [NCH-1:0]    drv_dmack,
  output logic [NCH-1:0]    tf_cs,
  output logic [NCH-1:0]    tf_alt_cs,
  output logic [2:0]        tf_reg,
  output logic              tf_rd,
  output logic              tf_wr,
  input  logic [DATA_W-1:0] tf_rdata
);
  logic              wr_s, rd_s, acc;
  logic [DATA_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  dma_sel;
  logic              win_en;
  logic [NCH-1:0]    stat_s, en_s, irq_s;
  logic              hit_any;
  dec_t              dec;

  assign wr_s = bus_wr;
  assign rd_s = bus_rd & ~bus_wr;
  assign acc  = wr_s | rd_s;

  assign win_en  = ctrl_q[CTRL_WIN_BIT];
  assign dma_sel = ctrl_q[CTRL_DMA_BIT +: SEL_W];

  icdc_decode u_dec (.addr(bus_addr), .win_en(win_en), .dec(dec));

  icdc_sync #(.W(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(drv_irq), .q(stat_s)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      icdc_chan u_chan (
        .clk(clk), .rst_n(rst_n),
        .mask_wr(wr_s & dec.mask[c]),
        .mask_rd(rd_s & dec.mask[c]),
        .stat(stat_s[c]),
        .en_q(en_s[c]),
        .irq(irq_s[c])
      );
      assign drv_dmack[c] = host_dack && (dma_sel == SEL_W'(c));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr_s && dec.ctrl) ctrl_q <= bus_wdata;
  end

  assign host_irq    = |irq_s;
  assign irq_pending = |stat_s;
  assign host_dreq   = drv_dmarq[dma_sel];

  assign tf_cs     = acc ? dec.tf  : '0;
  assign tf_alt_cs = acc ? dec.alt : '0;
  assign tf_reg    = dec.tf_reg;
  assign tf_rd     = rd_s && (|(dec.tf | dec.alt));
  assign tf_wr     = wr_s && (|(dec.tf | dec.alt));

  assign hit_any = dec.ctrl | dec.id | (|dec.mask) | (|dec.stat) |
                   (|dec.tf) | (|dec.alt);

  always_comb begin
    bus_rdata = '1;
    if (dec.ctrl) bus_rdata = ctrl_q;
    if (dec.id)   bus_rdata = {{(DATA_W-1){1'b0}}, CARD_ID[dec.id_idx]};
    for (int c = 0; c < NCH; c++) begin
      if (dec.stat[c])             bus_rdata = {{(DATA_W-1){1'b0}}, stat_s[c]};
      if (dec.tf[c] || dec.alt[c]) bus_rdata = tf_rdata;
    end
  end

  assert_irq_implies_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> irq_pending);
  assert_dack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_dmack));
  assert_closed_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (tf_cs == '0 && tf_alt_cs == '0 && !tf_rd && !tf_wr));
  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.ctrl, dec.id, dec.mask, dec.stat, dec.tf, dec.alt}));
  assert_unmapped_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit_any) |=> ($stable(ctrl_q) && $stable(en_s)));
  assert_zero_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && dec.ctrl && bus_wdata == '0) |=> (!win_en && dma_sel == '0));
endmodule

// File: tb/sim_dual_ide_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_ide_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic        host_irq, irq_pending;
  logic [1:0]  drv_dmarq = '0;
  logic        host_dreq;
  logic        host_dack = 1'b0;
  logic [1:0]  drv_dmack, tf_cs, tf_alt_cs;
  logic [2:0]  tf_reg;
  logic        tf_rd, tf_wr;
  logic [7:0]  tf_rdata = 8'h5A;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0] cs_s, alt_s;
  logic [2:0] reg_s;
  logic       trd_s, twr_s;
  logic [7:0] rd_d;

  always #2.5 clk = ~clk;

  dual_ide_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .host_irq(host_irq), .irq_pending(irq_pending),
    .drv_dmarq(drv_dmarq), .host_dreq(host_dreq), .host_dack(host_dack),
    .drv_dmack(drv_dmack), .tf_cs(tf_cs), .tf_alt_cs(tf_alt_cs),
    .tf_reg(tf_reg), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_rdata(tf_rdata)
  );

  // {write, addr[15:0], wdata, expected read data}
  localparam logic [32:0] VEC [16] = '{
    {1'b0, 16'h0000, 8'h00, 8'h00},
    {1'b0, 16'h2280, 8'h00, 8'h01},
    {1'b0, 16'h2284, 8'h00, 8'h01},
    {1'b0, 16'h2288, 8'h00, 8'h00},
    {1'b0, 16'h228C, 8'h00, 8'h00},
    {1'b0, 16'h1234, 8'h00, 8'hFF},
    {1'b0, 16'h2000, 8'h00, 8'hFF},
    {1'b1, 16'h0000, 8'h21, 8'h00},
    {1'b0, 16'h0000, 8'h00, 8'h21},
    {1'b0, 16'h21C0, 8'h00, 8'h5A},
    {1'b0, 16'h2010, 8'h00, 8'hFF},
    {1'b0, 16'h3380, 8'h00, 8'h5A},
    {1'b1, 16'h0100, 8'h55, 8'h00},
    {1'b0, 16'h0000, 8'h00, 8'h21},
    {1'b0, 16'h2290, 8'h00, 8'h00},
    {1'b0, 16'h3290, 8'h00, 8'h00}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:            return "R1";
      1, 2, 3, 4:   return "R6";
      5, 10, 13:    return "R9";
      6, 9, 11:     return "R8";
      8:            return "R7";
      default:      return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_rd(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; cs_s = tf_cs; alt_s = tf_alt_cs; reg_s = tf_reg; trd_s = tf_rd;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    #1;
    cs_s = tf_cs; reg_s = tf_reg; twr_s = tf_wr;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);
    // R1 reset state at the ports
    check("R1 host_irq", host_irq, 0);
    check("R1 irq_pending", irq_pending, 0);
    check("R1 drv_dmack", drv_dmack, 0);
    check("R1 tf_cs", tf_cs, 0);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][32]) do_wr(VEC[i][29:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][29:16], rd_d);
        check(vec_tag(i), rd_d, VEC[i][7:0]);
      end
    end

    // R7 DMA routing with select = 1
    drv_dmarq = 2'b10; #1;
    check("R7 dreq ch1", host_dreq, 1);
    drv_dmarq = 2'b01; #1;
    check("R7 dreq other", host_dreq, 0);
    host_dack = 1'b1; #1;
    check("R7 dmack", drv_dmack, 2'b10);
    host_dack = 1'b0; drv_dmarq = '0;

    // R8 taskfile selects
    do_rd(14'h21C0, rd_d);
    check("R8 cs", cs_s, 2'b01);
    check("R8 reg", reg_s, 7);
    check("R8 rd", trd_s, 1);
    do_rd(14'h3380, rd_d);
    check("R8 alt", alt_s, 2'b10);
    check("R8 alt cs", cs_s, 2'b00);
    do_wr(14'h2040, 8'h77);
    check("R8 wr", twr_s, 1);
    check("R8 wr reg", reg_s, 1);

    // R3 / R4 synchroniser delay
    @(negedge clk); drv_irq = 2'b01;
    @(posedge clk); #1;
    check("R4 pending after 1 edge", irq_pending, 0);
    @(posedge clk); #1;
    check("R4 pending after 2 edges", irq_pending, 1);
    check("R5 no enable", host_irq, 0);
    do_rd(14'h2290, rd_d); check("R3 status ch0", rd_d, 8'h01);
    do_rd(14'h3290, rd_d); check("R3 status ch1", rd_d, 8'h00);

    // R2 / R5 enable and disable
    do_wr(14'h2200, 8'h00);
    check("R5 enabled irq", host_irq, 1);
    do_rd(14'h2200, rd_d);
    check("R2 mask read data", rd_d, 8'hFF);
    check("R2 read disables", host_irq, 0);
    check("R4 pending still", irq_pending, 1);
    do_wr(14'h3200, 8'h00);
    check("R5 other channel enable", host_irq, 0);
    do_rd(14'h3200, rd_d);

    // R9 unmapped read leaves enable alone
    do_wr(14'h2200, 8'hA5);
    check("R2 write any data", host_irq, 1);
    do_rd(14'h2204, rd_d);
    check("R9 unmapped data", rd_d, 8'hFF);
    check("R9 enable kept", host_irq, 1);
    do_rd(14'h2200, rd_d);
    drv_irq = 2'b00;
    wait_cycles(3);
    check("R4 pending clears", irq_pending, 0);

    // R5 same-edge: status rises while enable write lands
    @(negedge clk); drv_irq = 2'b10;
    @(negedge clk);
    bus_addr = 14'h3200; bus_wr = 1'b1;
    #1;
    check("R5 before shared edge", host_irq, 0);
    @(negedge clk); bus_wr = 1'b0;
    check("R5 after shared edge", host_irq, 1);
    do_rd(14'h3200, rd_d);
    check("R2 clear ch1", host_irq, 0);
    drv_irq = 2'b00;
    wait_cycles(3);

    // R10 writing zero closes window and routes DMA to channel 0
    do_wr(14'h0000, 8'h00);
    do_rd(14'h2000, rd_d);
    check("R10 window closed", rd_d, 8'hFF);
    check("R10 no cs", cs_s, 2'b00);
    host_dack = 1'b1; #1;
    check("R10 dmack ch0", drv_dmack, 2'b01);
    host_dack = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule